// File: doc/BRIEF.md
# Program-Order Pointer Queue with Out-of-Order Removal

This block tracks the program order of instructions that are in flight in a core whose results may retire out of order. Each queue entry holds the index of a slot in a separate instruction window, plus a bit mask over the entries of an undo buffer. The undo buffer holds register values that an exception may have to restore. Position 0 of the queue is the oldest instruction (the head). The youngest occupied position is the tail.

New instructions are appended at the tail through a valid/ready dispatch port. A valid/ready commit port removes any entry by its window slot. When the removed entry is not the head, only this small queue closes the gap. The window contents do not move. The removed entry's undo mask, plus the bit of any undo entry written by that commit, is ORed into the next-older entry. When the head commits, its mask is sent out as a release request for the undo buffer. An exception flush drops the faulting entry and every younger one.

Back-pressure: a transfer happens on a cycle where valid and ready are both high. `disp_ready` is low while the queue is full or a flush is being requested. `cmt_ready` is low while a flush is being requested, and also for a memory commit whose slot is present but not at the head. `cmt_ready` may depend on the commit inputs of the same cycle.

Top module: `prog_order_queue`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `count`=0, `rel_valid`=0, `err_miss`=0, `head_slot`=0 and `head_vec`=0. Both head outputs read 0 whenever the queue is empty.
- R2: An accepted dispatch appends its slot index at the tail with a cleared undo mask, so `count` rises by one when no commit is accepted in the same cycle. `head_slot` always shows the oldest remaining entry.
- R3: When `count` equals DEPTH, `full`=1 and `disp_ready`=0. A dispatch offered while full leaves the queue unchanged.
- R4: An accepted commit of a slot at position p>0 removes that entry, and every younger entry moves one position toward the head in its original relative order.
- R5: On an accepted commit at position p>0, the entry at p-1 gets its mask ORed with the committing entry's mask. When `cmt_undo_wr`=1, it also gets bit `cmt_undo_idx` set. Bit k of a mask stands for undo entry k.
- R6: An accepted commit of the head gives `rel_valid`=1 and `rel_mask` equal to the head's mask, on the cycle after the accepting edge, for one cycle. Its `cmt_undo_wr` changes no mask.
- R7: A commit with `cmt_is_mem`=1 whose slot is present but not at the head is refused (`cmt_ready`=0), and the queue stays unchanged.
- R8: When `flush_valid`=1 and `flush_slot` is present at position f, `count` becomes f, and the older entries keep their order and masks. A flush naming an absent slot changes nothing. While `flush_valid`=1, both readies are 0.
- R9: An accepted commit naming a slot that is not in the queue leaves the entries unchanged. It pulses `err_miss` for one cycle after the accepting edge.
- R10: A dispatch and a commit accepted in the same cycle both take effect. The gap is closed first and the new slot lands behind the remaining entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch can be accepted |
| disp_slot | input | SLOT_W | Window slot of the new instruction |
| cmt_valid | input | 1 | Commit request |
| cmt_ready | output | 1 | Commit can be accepted |
| cmt_slot | input | SLOT_W | Window slot being committed |
| cmt_is_mem | input | 1 | Committing instruction is a memory operation |
| cmt_undo_wr | input | 1 | This commit wrote an undo entry |
| cmt_undo_idx | input | UNDO_W | Index of the undo entry written |
| flush_valid | input | 1 | Exception flush request |
| flush_slot | input | SLOT_W | Window slot of the faulting instruction |
| rel_valid | output | 1 | Undo release request (head committed) |
| rel_mask | output | UNDO_N | Undo entries that may be freed |
| err_miss | output | 1 | A commit named an absent slot |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |
| count | output | CNT_W | Number of occupied entries |
| head_slot | output | SLOT_W | Window slot of the oldest entry |
| head_vec | output | UNDO_N | Undo mask of the oldest entry |

## Verification
The removal function is driven with four patterns:
- commits at the head;
- commits in the middle;
- commits at the tail;
- a commit paired with a dispatch in the same cycle.

After each pattern the bench drains the queue through the head, which reveals both an ordering error and an off-by-one shift. Mask merging is tested with two chained out-of-order commits that write different undo indices. The resulting head mask tells a correct OR apart from an overwrite and from a merge into the wrong neighbour. Memory commits away from the head, misses, and flushes of present and absent slots each show whether the queue is left untouched or cut at the right point.

// File: rtl/oq_pkg.sv
package oq_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE     = 3'd0,
    ACT_CMT_HEAD = 3'd1,
    ACT_CMT_MID  = 3'd2,
    ACT_CMT_MISS = 3'd3,
    ACT_FLUSH    = 3'd4
  } q_action_e;

endpackage

// File: rtl/oq_locate.sv
module oq_locate #(
  parameter int DEPTH  = 8,
  parameter int SLOT_W = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][SLOT_W-1:0] slots,
  input  logic [CNT_W-1:0]             count,
  input  logic [SLOT_W-1:0]            key,
  output logic                         hit,
  output logic [PTR_W-1:0]             pos
);

  logic [DEPTH-1:0] occ;
  logic [DEPTH-1:0] match;

  // Occupancy thermometer: positions below count are live.
  assign occ = ~({DEPTH{1'b1}} << count);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = occ[g] && (slots[g] == key);
  end

  // Lowest (oldest) matching position wins.
  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        pos = PTR_W'(i);
      end
    end
  end

endmodule

// File: rtl/oq_collapse.sv
module oq_collapse #(
  parameter int DEPTH  = 8,
  parameter int SLOT_W = 3,
  parameter int UNDO_N = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][SLOT_W-1:0] slots,
  input  logic [DEPTH-1:0][UNDO_N-1:0] vecs,
  input  logic [CNT_W-1:0]             count,
  input  logic                         rm_en,
  input  logic [PTR_W-1:0]             rm_pos,
  input  logic                         merge_en,
  input  logic [UNDO_N-1:0]            merge_bits,
  input  logic                         app_en,
  input  logic [SLOT_W-1:0]            app_slot,
  input  logic                         trunc_en,
  input  logic [PTR_W-1:0]             trunc_pos,
  output logic [DEPTH-1:0][SLOT_W-1:0] nxt_slots,
  output logic [DEPTH-1:0][UNDO_N-1:0] nxt_vecs,
  output logic [CNT_W-1:0]             nxt_count
);

  logic [DEPTH-1:0] shift_mask;
  logic [DEPTH-1:0] merge_sel;
  logic [DEPTH-1:0] app_sel;
  logic [DEPTH-1:0] drop_mask;
  logic [CNT_W-1:0] base_cnt;

  assign base_cnt   = count - CNT_W'(rm_en);
  assign shift_mask = rm_en ? ({DEPTH{1'b1}} << rm_pos) : '0;
  assign merge_sel  = merge_en ? ((DEPTH'(1) << rm_pos) >> 1) : '0;
  assign app_sel    = app_en ? (DEPTH'(1) << base_cnt) : '0;
  assign drop_mask  = trunc_en ? ({DEPTH{1'b1}} << trunc_pos) : '0;

  always_comb begin
    if (trunc_en) begin
      nxt_count = CNT_W'(trunc_pos);
    end else begin
      nxt_count = base_cnt + CNT_W'(app_en);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [SLOT_W-1:0] sh_slot;
    logic [UNDO_N-1:0] sh_vec;

    if (g < DEPTH - 1) begin : g_mid
      always_comb begin
        if (shift_mask[g]) begin
          sh_slot = slots[g+1];
          sh_vec  = vecs[g+1];
        end else begin
          sh_slot = slots[g];
          sh_vec  = vecs[g];
        end
        if (merge_sel[g]) begin
          sh_vec = sh_vec | merge_bits;
        end
      end
    end else begin : g_end
      always_comb begin
        if (shift_mask[g]) begin
          sh_slot = '0;
          sh_vec  = '0;
        end else begin
          sh_slot = slots[g];
          sh_vec  = vecs[g];
        end
      end
    end

    always_comb begin
      nxt_slots[g] = sh_slot;
      nxt_vecs[g]  = sh_vec;
      if (drop_mask[g]) begin
        nxt_slots[g] = '0;
        nxt_vecs[g]  = '0;
      end
      if (app_sel[g]) begin
        nxt_slots[g] = app_slot;
        nxt_vecs[g]  = '0;
      end
    end
  end

endmodule

// File: rtl/prog_order_queue.sv
module prog_order_queue
  import oq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int UNDO_N  = 8,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int UNDO_W = $clog2(UNDO_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [SLOT_W-1:0] disp_slot,
  input  logic              cmt_valid,
  output logic              cmt_ready,
  input  logic [SLOT_W-1:0] cmt_slot,
  input  logic              cmt_is_mem,
  input  logic              cmt_undo_wr,
  input  logic [UNDO_W-1:0] cmt_undo_idx,
  input  logic              flush_valid,
  input  logic [SLOT_W-1:0] flush_slot,
  output logic              rel_valid,
  output logic [UNDO_N-1:0] rel_mask,
  output logic              err_miss,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic [SLOT_W-1:0] head_slot,
  output logic [UNDO_N-1:0] head_vec
);

  logic [DEPTH-1:0][SLOT_W-1:0] slot_q, slot_d;
  logic [DEPTH-1:0][UNDO_N-1:0] vec_q, vec_d;
  logic [CNT_W-1:0]             cnt_q, cnt_d;
  logic                         rel_valid_q, err_q;
  logic [UNDO_N-1:0]            rel_mask_q;

  logic             c_hit, f_hit;
  logic [PTR_W-1:0] c_pos, f_pos;
  logic             c_at_head;
  logic             cmt_fire, disp_fire;
  logic [UNDO_N-1:0] undo_bit;
  logic [UNDO_N-1:0] merge_bits;
  q_action_e        act;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign count = cnt_q;

  oq_locate #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_find_cmt (
    .slots (slot_q),
    .count (cnt_q),
    .key   (cmt_slot),
    .hit   (c_hit),
    .pos   (c_pos)
  );

  oq_locate #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_find_flush (
    .slots (slot_q),
    .count (cnt_q),
    .key   (flush_slot),
    .hit   (f_hit),
    .pos   (f_pos)
  );

  assign c_at_head  = c_hit && (c_pos == '0);
  assign disp_ready = !flush_valid && !full;
  assign cmt_ready  = !flush_valid && !(cmt_is_mem && c_hit && !c_at_head);
  assign disp_fire  = disp_valid && disp_ready;
  assign cmt_fire   = cmt_valid && cmt_ready;

  // Classify this cycle's structural action on the queue.
  always_comb begin
    act = ACT_IDLE;
    if (flush_valid && f_hit) begin
      act = ACT_FLUSH;
    end else if (cmt_fire) begin
      if (!c_hit) begin
        act = ACT_CMT_MISS;
      end else if (c_at_head) begin
        act = ACT_CMT_HEAD;
      end else begin
        act = ACT_CMT_MID;
      end
    end
  end

  assign undo_bit   = cmt_undo_wr ? (UNDO_N'(1) << cmt_undo_idx) : '0;
  assign merge_bits = vec_q[c_pos] | undo_bit;

  oq_collapse #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .UNDO_N(UNDO_N)) u_collapse (
    .slots      (slot_q),
    .vecs       (vec_q),
    .count      (cnt_q),
    .rm_en      ((act == ACT_CMT_HEAD) || (act == ACT_CMT_MID)),
    .rm_pos     (c_pos),
    .merge_en   (act == ACT_CMT_MID),
    .merge_bits (merge_bits),
    .app_en     (disp_fire),
    .app_slot   (disp_slot),
    .trunc_en   (act == ACT_FLUSH),
    .trunc_pos  (f_pos),
    .nxt_slots  (slot_d),
    .nxt_vecs   (vec_d),
    .nxt_count  (cnt_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q      <= '0;
      vec_q       <= '0;
      cnt_q       <= '0;
      rel_valid_q <= 1'b0;
      rel_mask_q  <= '0;
      err_q       <= 1'b0;
    end else begin
      slot_q      <= slot_d;
      vec_q       <= vec_d;
      cnt_q       <= cnt_d;
      rel_valid_q <= (act == ACT_CMT_HEAD);
      rel_mask_q  <= (act == ACT_CMT_HEAD) ? vec_q[0] : '0;
      err_q       <= (act == ACT_CMT_MISS);
    end
  end

  assign rel_valid = rel_valid_q;
  assign rel_mask  = rel_mask_q;
  assign err_miss  = err_q;
  assign head_slot = empty ? '0 : slot_q[0];
  assign head_vec  = empty ? '0 : vec_q[0];

endmodule

// File: rtl/prog_order_queue_chk.sv
module prog_order_queue_chk #(
  parameter int DEPTH   = 8,
  parameter int UNDO_N  = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic             cmt_valid,
  input logic             cmt_ready,
  input logic             flush_valid,
  input logic             rel_valid,
  input logic             err_miss,
  input logic             full,
  input logic [CNT_W-1:0] count
);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !disp_ready);

  p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (!disp_ready && !cmt_ready));

  p_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && !cmt_valid && !flush_valid)
      |=> (count == $past(count) + CNT_W'(1)));

  p_release_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> $past(cmt_valid && cmt_ready));

  p_miss_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_miss |-> (!rel_valid && $past(cmt_valid && cmt_ready)));

endmodule

bind prog_order_queue prog_order_queue_chk #(.DEPTH(DEPTH), .UNDO_N(UNDO_N)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .disp_valid  (disp_valid),
  .disp_ready  (disp_ready),
  .cmt_valid   (cmt_valid),
  .cmt_ready   (cmt_ready),
  .flush_valid (flush_valid),
  .rel_valid   (rel_valid),
  .err_miss    (err_miss),
  .full        (full),
  .count       (count)
);

// File: tb/prog_order_queue_tb_top.sv
`timescale 1ns/1ps
module prog_order_queue_tb_top;

  localparam int DEPTH = 8;
  localparam int UNDO_N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 1'b0, disp_ready;
  logic [2:0] disp_slot = '0;
  logic       cmt_valid = 1'b0, cmt_ready;
  logic [2:0] cmt_slot = '0;
  logic       cmt_is_mem = 1'b0, cmt_undo_wr = 1'b0;
  logic [2:0] cmt_undo_idx = '0;
  logic       flush_valid = 1'b0;
  logic [2:0] flush_slot = '0;
  logic       rel_valid, err_miss, full, empty;
  logic [7:0] rel_mask, head_vec;
  logic [3:0] count;
  logic [2:0] head_slot;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  prog_order_queue #(.DEPTH(DEPTH), .UNDO_N(UNDO_N)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_slot(disp_slot),
    .cmt_valid(cmt_valid), .cmt_ready(cmt_ready), .cmt_slot(cmt_slot),
    .cmt_is_mem(cmt_is_mem), .cmt_undo_wr(cmt_undo_wr), .cmt_undo_idx(cmt_undo_idx),
    .flush_valid(flush_valid), .flush_slot(flush_slot),
    .rel_valid(rel_valid), .rel_mask(rel_mask), .err_miss(err_miss),
    .full(full), .empty(empty), .count(count),
    .head_slot(head_slot), .head_vec(head_vec)
  );

  // Vector: {op(1: commit, 0: dispatch), slot[2:0], exp_count[3:0], exp_head[2:0]}
  localparam logic [10:0] VEC [10] = '{
    {1'b0, 3'd3, 4'd1, 3'd3},
    {1'b0, 3'd5, 4'd2, 3'd3},
    {1'b0, 3'd1, 4'd3, 3'd3},
    {1'b0, 3'd6, 4'd4, 3'd3},
    {1'b1, 3'd5, 4'd3, 3'd3},   // middle removal
    {1'b1, 3'd3, 4'd2, 3'd1},   // head removal
    {1'b0, 3'd2, 4'd3, 3'd1},
    {1'b1, 3'd2, 4'd2, 3'd1},   // tail removal
    {1'b1, 3'd1, 4'd1, 3'd6},
    {1'b1, 3'd6, 4'd0, 3'd0}
  };

  localparam int R10_ORD [7] = '{1, 2, 3, 5, 6, 7, 0};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    disp_valid = 1'b0; cmt_valid = 1'b0; cmt_is_mem = 1'b0;
    cmt_undo_wr = 1'b0; flush_valid = 1'b0;
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic dispatch(input int s);
    disp_valid = 1'b1; disp_slot = 3'(s);
    cycle();
  endtask

  task automatic commit(input int s, input bit mem, input bit uw, input int ui);
    cmt_valid = 1'b1; cmt_slot = 3'(s); cmt_is_mem = mem;
    cmt_undo_wr = uw; cmt_undo_idx = 3'(ui);
    cycle();
  endtask

  task automatic flush(input int s);
    flush_valid = 1'b1; flush_slot = 3'(s);
    cycle();
  endtask

  initial begin
    #(5.0 * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 count", int'(count), 0);
    check("R1 rel_valid", int'(rel_valid), 0);
    check("R1 err_miss", int'(err_miss), 0);
    check("R1 head_slot", int'(head_slot), 0);

    // R2 R4 table walk: appends and head/middle/tail removals
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][10]) commit(int'(VEC[i][9:7]), 1'b0, 1'b0, 0);
      else dispatch(int'(VEC[i][9:7]));
      check("R4 table count", int'(count), int'(VEC[i][6:3]));
      check("R2 table head", int'(head_slot), int'(VEC[i][2:0]));
    end

    // R3 fill to full, then refused dispatch
    for (int s = 0; s < DEPTH; s++) dispatch(s);
    check("R3 full", int'(full), 1);
    check("R3 disp_ready", int'(disp_ready), 0);
    dispatch(7);
    check("R3 count after refused", int'(count), 8);

    // R10 simultaneous commit and dispatch
    commit(0, 1'b0, 1'b0, 0);
    disp_valid = 1'b1; disp_slot = 3'd0;
    cmt_valid = 1'b1; cmt_slot = 3'd4;
    cycle();
    check("R10 count", int'(count), 7);
    for (int k = 0; k < 7; k++) begin
      check("R10 order", int'(head_slot), R10_ORD[k]);
      commit(R10_ORD[k], 1'b0, 1'b0, 0);
    end
    check("R10 drained", int'(empty), 1);

    // R5 chained merges, R6 release
    dispatch(2); dispatch(4); dispatch(6);
    commit(6, 1'b0, 1'b1, 1);
    commit(4, 1'b0, 1'b1, 5);
    check("R5 merged head_vec", int'(head_vec), 8'h22);
    check("R5 count", int'(count), 1);
    commit(2, 1'b0, 1'b1, 7);
    check("R6 rel_valid", int'(rel_valid), 1);
    check("R6 rel_mask", int'(rel_mask), 8'h22);
    #5;
    check("R6 rel pulse ends", int'(rel_valid), 0);

    // R7 memory commit away from head
    dispatch(1); dispatch(3);
    cmt_valid = 1'b1; cmt_slot = 3'd3; cmt_is_mem = 1'b1;
    #1;
    check("R7 cmt_ready", int'(cmt_ready), 0);
    cycle();
    check("R7 count", int'(count), 2);
    commit(1, 1'b1, 1'b0, 0);
    check("R7 head mem commit", int'(head_slot), 3);

    // R9 absent slot
    commit(7, 1'b0, 1'b0, 0);
    check("R9 err_miss", int'(err_miss), 1);
    check("R9 count", int'(count), 1);
    check("R9 head", int'(head_slot), 3);
    #5;
    check("R9 pulse ends", int'(err_miss), 0);

    // R8 flush
    dispatch(0); dispatch(5); dispatch(2);
    flush_valid = 1'b1; flush_slot = 3'd5;
    disp_valid = 1'b1; disp_slot = 3'd7;
    #1;
    check("R8 disp_ready during flush", int'(disp_ready), 0);
    cycle();
    check("R8 count after flush", int'(count), 2);
    flush(6);
    check("R8 absent flush", int'(count), 2);
    check("R8 head kept", int'(head_slot), 3);
    commit(3, 1'b0, 1'b0, 0);
    check("R8 older order", int'(head_slot), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule